// File: doc/BRIEF.md
# Three-Bus Dual-Port RAM Page Arbiter

This block owns one page of fast on-chip RAM and shares it among three bus masters: a DMA bus, a CPU data bus and a CPU instruction-fetch bus. The page has two physical ports, and each port can read or write one word per cycle. At most two requesters are served in any cycle. Requesters are placed on ports in a fixed priority order: DMA first, CPU data second, instruction fetch last. A requester that finds no free port is stalled by holding its ready low.

CPU-side accesses complete in a single cycle. A request is accepted in the cycle its ready is high, a write takes effect at that clock edge, and read data comes back with a read-valid strobe one cycle later. The DMA bus runs on a slower clock, so it is modelled with a parameterised number of extra wait cycles. For its whole request the DMA bus holds a port. The instruction-fetch bus has no write path at all.

Top module: `ram_page_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, `dma_rvalid`, `dbus_rvalid` and `ibus_rvalid` are low, and `dma_ready` stays low while `dma_req` is low.
- R2: `dbus_ready` equals `dbus_req` in every cycle, because only the DMA bus outranks the data bus and a second port always remains.
- R3: `ibus_ready` is high whenever `ibus_req` is high and at most one of `dma_req` and `dbus_req` is high. It is low whenever both are high.
- R4: The fetch bus never changes the page contents. A word read by the fetch bus still holds its prior value afterwards.
- R5: An accepted CPU read (`dbus_req` with `dbus_we` low, or `ibus_req`, with ready high) raises that bus's rvalid in the next cycle, with the word stored at the address. A read in the same cycle as a write to the same word returns the value from before the write.
- R6: An accepted data-bus write updates only the bytes whose strobe bit is set. Strobe bit i covers data bits 8i+7..8i. The new value is visible to a read accepted in the following cycle.
- R7: With `dma_req` held high, `dma_ready` is low in the first DMA_WAIT cycles and high in cycle DMA_WAIT+1. The DMA read or write happens only in that ready cycle.
- R8: While `dma_req` is high, including its wait cycles, the DMA bus holds one port. If `dbus_req` is also high, the fetch bus is stalled.
- R9: If the DMA bus and the data bus write the same word in the same cycle, bytes strobed by both take the DMA data. Bytes strobed by only one bus take that bus's data, and unstrobed bytes keep their value.
- R10: A DMA read completed in its ready cycle raises `dma_rvalid` in the next cycle, with the stored word on `dma_rdata`. `dma_rvalid` stays low after DMA wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_req | input | 1 | DMA access request, held until ready |
| dma_we | input | 1 | DMA write enable |
| dma_addr | input | AW | DMA word address |
| dma_wdata | input | DW | DMA write data |
| dma_strb | input | DW/8 | DMA byte strobes |
| dma_ready | output | 1 | DMA access completes this cycle |
| dma_rdata | output | DW | DMA read data |
| dma_rvalid | output | 1 | DMA read data valid |
| dbus_req | input | 1 | CPU data request |
| dbus_we | input | 1 | CPU data write enable |
| dbus_addr | input | AW | CPU data word address |
| dbus_wdata | input | DW | CPU data write data |
| dbus_strb | input | DW/8 | CPU data byte strobes |
| dbus_ready | output | 1 | CPU data request accepted |
| dbus_rdata | output | DW | CPU data read data |
| dbus_rvalid | output | 1 | CPU data read data valid |
| ibus_req | input | 1 | Instruction-fetch read request |
| ibus_addr | input | AW | Instruction-fetch word address |
| ibus_ready | output | 1 | Fetch request accepted |
| ibus_rdata | output | DW | Fetch read data |
| ibus_rvalid | output | 1 | Fetch read data valid |

## Verification
The bench builds the block with a 32-bit word, a 16-word page and DMA_WAIT of 2. The small page lets every word be written and read back against an arithmetic reference. A wait of two gives the DMA bus two distinct stall cycles in which to test port occupancy and the absence of an early access. All eight combinations of the three request lines are swept to cover port assignment. The same-word collision and the same-cycle read-before-write cases are then driven deliberately with partial strobes.

// File: rtl/rpa_pkg.sv
package rpa_pkg;

    // Requester identity, value order is also priority order (lowest wins)
    typedef enum logic [1:0] {
        BUS_DMA  = 2'd0,
        BUS_DBUS = 2'd1,
        BUS_IBUS = 2'd2
    } bus_e;

    localparam int NUM_BUS  = 3;
    localparam int NUM_PORT = 2;

    // What a physical port carries this cycle
    typedef struct packed {
        logic act;
        bus_e src;
    } port_sel_t;

    function automatic logic is_writer(bus_e b);
        return b != BUS_IBUS;
    endfunction

endpackage

// File: rtl/rpa_dma_timer.sv
module rpa_dma_timer #(
    parameter int WAIT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic go
);
    localparam int CW = (WAIT > 0) ? $clog2(WAIT + 1) : 1;

    logic [CW-1:0] cnt_q;

    assign go = req && (cnt_q == CW'(WAIT));

    always_ff @(posedge clk) begin
        if (rst || !req || go) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rpa_grant.sv
module rpa_grant import rpa_pkg::*; #(
    parameter int NPORT = NUM_PORT
) (
    input  logic [NUM_BUS-1:0] req,
    output logic [NUM_BUS-1:0] grant,
    output port_sel_t [NPORT-1:0] psel
);
    always_comb begin
        int nxt;
        nxt   = 0;
        grant = '0;
        for (int p = 0; p < NPORT; p++) psel[p] = '{act: 1'b0, src: BUS_DMA};
        for (int b = 0; b < NUM_BUS; b++) begin
            if (req[b] && nxt < NPORT) begin
                psel[nxt] = '{act: 1'b1, src: bus_e'(b)};
                grant[b]  = 1'b1;
                nxt       = nxt + 1;
            end
        end
    end
endmodule

// File: rtl/rpa_mem.sv
module rpa_mem #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    parameter int NPORT = 2,
    localparam int AW   = $clog2(DEPTH),
    localparam int SW   = DW / 8
) (
    input  logic                       clk,
    input  logic [NPORT-1:0]           en,
    input  logic [NPORT-1:0]           we,
    input  logic [NPORT-1:0][AW-1:0]   addr,
    input  logic [NPORT-1:0][DW-1:0]   wdata,
    input  logic [NPORT-1:0][SW-1:0]   strb,
    output logic [NPORT-1:0][DW-1:0]   rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Higher port index first so port 0 (higher priority) lands last
    always_ff @(posedge clk) begin
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (en[p] && we[p]) begin
                for (int b = 0; b < SW; b++) begin
                    if (strb[p][b]) mem[addr[p]][8*b +: 8] <= wdata[p][8*b +: 8];
                end
            end
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (en[p] && !we[p]) rdata[p] <= mem[addr[p]];
        end
    end
endmodule

// File: rtl/ram_page_arbiter.sv
module ram_page_arbiter import rpa_pkg::*; #(
    parameter int DW       = 32,
    parameter int DEPTH    = 64,
    parameter int DMA_WAIT = 2,
    localparam int AW      = $clog2(DEPTH),
    localparam int SW      = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dma_req,
    input  logic          dma_we,
    input  logic [AW-1:0] dma_addr,
    input  logic [DW-1:0] dma_wdata,
    input  logic [SW-1:0] dma_strb,
    output logic          dma_ready,
    output logic [DW-1:0] dma_rdata,
    output logic          dma_rvalid,
    input  logic          dbus_req,
    input  logic          dbus_we,
    input  logic [AW-1:0] dbus_addr,
    input  logic [DW-1:0] dbus_wdata,
    input  logic [SW-1:0] dbus_strb,
    output logic          dbus_ready,
    output logic [DW-1:0] dbus_rdata,
    output logic          dbus_rvalid,
    input  logic          ibus_req,
    input  logic [AW-1:0] ibus_addr,
    output logic          ibus_ready,
    output logic [DW-1:0] ibus_rdata,
    output logic          ibus_rvalid
);
    localparam int NP = NUM_PORT;

    logic                 dma_go;
    logic [NUM_BUS-1:0]   req_v, grant_v;
    port_sel_t [NP-1:0]   psel;
    logic [NP-1:0]        p_en, p_we;
    logic [NP-1:0][AW-1:0] p_addr;
    logic [NP-1:0][DW-1:0] p_wdata, p_rdata;
    logic [NP-1:0][SW-1:0] p_strb;
    logic [NP-1:0]        rd_q;
    bus_e [NP-1:0]        src_q;

    rpa_dma_timer #(.WAIT(DMA_WAIT)) u_tmr (
        .clk (clk), .rst (rst), .req (dma_req), .go (dma_go)
    );

    assign req_v[BUS_DMA]  = dma_req;
    assign req_v[BUS_DBUS] = dbus_req;
    assign req_v[BUS_IBUS] = ibus_req;

    rpa_grant #(.NPORT(NP)) u_grant (
        .req (req_v), .grant (grant_v), .psel (psel)
    );

    assign dma_ready  = dma_go;
    assign dbus_ready = grant_v[BUS_DBUS];
    assign ibus_ready = grant_v[BUS_IBUS];

    for (genvar p = 0; p < NP; p++) begin : g_port
        always_comb begin
            logic wr;
            case (psel[p].src)
                BUS_DMA: begin
                    p_en[p] = psel[p].act && dma_go;
                    wr = dma_we; p_addr[p] = dma_addr;
                    p_wdata[p] = dma_wdata; p_strb[p] = dma_strb;
                end
                BUS_DBUS: begin
                    p_en[p] = psel[p].act;
                    wr = dbus_we; p_addr[p] = dbus_addr;
                    p_wdata[p] = dbus_wdata; p_strb[p] = dbus_strb;
                end
                default: begin
                    p_en[p] = psel[p].act;
                    wr = 1'b0; p_addr[p] = ibus_addr;
                    p_wdata[p] = '0; p_strb[p] = '0;
                end
            endcase
            p_we[p] = p_en[p] && wr && is_writer(psel[p].src);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                rd_q[p]  <= 1'b0;
                src_q[p] <= BUS_DMA;
            end else begin
                rd_q[p]  <= p_en[p] && !p_we[p];
                src_q[p] <= psel[p].src;
            end
        end
    end

    rpa_mem #(.DW(DW), .DEPTH(DEPTH), .NPORT(NP)) u_mem (
        .clk (clk), .en (p_en), .we (p_we), .addr (p_addr),
        .wdata (p_wdata), .strb (p_strb), .rdata (p_rdata)
    );

    always_comb begin
        dma_rvalid = 1'b0; dbus_rvalid = 1'b0; ibus_rvalid = 1'b0;
        dma_rdata  = '0;   dbus_rdata  = '0;   ibus_rdata  = '0;
        for (int p = 0; p < NP; p++) begin
            if (rd_q[p]) begin
                case (src_q[p])
                    BUS_DMA:  begin dma_rvalid  = 1'b1; dma_rdata  = p_rdata[p]; end
                    BUS_DBUS: begin dbus_rvalid = 1'b1; dbus_rdata = p_rdata[p]; end
                    default:  begin ibus_rvalid = 1'b1; ibus_rdata = p_rdata[p]; end
                endcase
            end
        end
    end
endmodule

// File: rtl/rpa_checker.sv
module rpa_checker #(
    parameter int DMA_WAIT = 2
) (
    input logic clk,
    input logic rst,
    input logic dma_req,
    input logic dma_we,
    input logic dma_ready,
    input logic dma_rvalid,
    input logic dbus_req,
    input logic dbus_we,
    input logic dbus_ready,
    input logic dbus_rvalid,
    input logic ibus_req,
    input logic ibus_ready,
    input logic ibus_rvalid
);
    int unsigned held;

    always_ff @(posedge clk) begin
        if (rst || !dma_req || dma_ready) held <= 0;
        else                              held <= held + 1;
    end

    AST_DBUS_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        dbus_req |-> dbus_ready) else $error("dbus stalled"); // R2

    AST_IBUS_STALL: assert property (@(posedge clk) disable iff (rst)
        (ibus_req && dma_req && dbus_req) |-> !ibus_ready) else $error("ibus not stalled"); // R8

    AST_IBUS_GRANT: assert property (@(posedge clk) disable iff (rst)
        (ibus_req && !(dma_req && dbus_req)) |-> ibus_ready) else $error("ibus stalled"); // R3

    AST_PORT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        $countones({dma_req, dbus_ready, ibus_ready}) <= 2) else $error("too many grants"); // R3

    AST_DMA_WAIT: assert property (@(posedge clk) disable iff (rst)
        dma_ready |-> (held == DMA_WAIT)) else $error("dma early"); // R7

    AST_DMA_NOT_LATE: assert property (@(posedge clk) disable iff (rst)
        (dma_req && held == DMA_WAIT) |-> dma_ready) else $error("dma late"); // R7

    AST_DMA_RVALID: assert property (@(posedge clk) disable iff (rst)
        dma_rvalid |-> $past(dma_ready && !dma_we)) else $error("dma rvalid"); // R10

    AST_DBUS_RVALID: assert property (@(posedge clk) disable iff (rst)
        dbus_rvalid |-> $past(dbus_ready && !dbus_we)) else $error("dbus rvalid"); // R5

    AST_IBUS_RVALID: assert property (@(posedge clk) disable iff (rst)
        ibus_rvalid |-> $past(ibus_ready)) else $error("ibus rvalid"); // R5
endmodule

bind ram_page_arbiter rpa_checker #(.DMA_WAIT(DMA_WAIT)) u_chk (
    .clk (clk), .rst (rst),
    .dma_req (dma_req), .dma_we (dma_we), .dma_ready (dma_ready), .dma_rvalid (dma_rvalid),
    .dbus_req (dbus_req), .dbus_we (dbus_we), .dbus_ready (dbus_ready), .dbus_rvalid (dbus_rvalid),
    .ibus_req (ibus_req), .ibus_ready (ibus_ready), .ibus_rvalid (ibus_rvalid)
);

// File: tb/tb_ram_page_arbiter.sv
module tb_ram_page_arbiter;
    localparam int DW = 32, DEPTH = 16, WT = 2, AW = 4, SW = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic dma_req = 0, dma_we = 0, dbus_req = 0, dbus_we = 0, ibus_req = 0;
    logic [AW-1:0] dma_addr = '0, dbus_addr = '0, ibus_addr = '0;
    logic [DW-1:0] dma_wdata = '0, dbus_wdata = '0;
    logic [SW-1:0] dma_strb = '0, dbus_strb = '0;
    logic dma_ready, dma_rvalid, dbus_ready, dbus_rvalid, ibus_ready, ibus_rvalid;
    logic [DW-1:0] dma_rdata, dbus_rdata, ibus_rdata;

    logic [DW-1:0] model [DEPTH];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ram_page_arbiter #(.DW(DW), .DEPTH(DEPTH), .DMA_WAIT(WT)) dut (.*);

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        dma_req = 0; dma_we = 0; dbus_req = 0; dbus_we = 0; ibus_req = 0;
    endtask

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [SW-1:0] s);
        for (int b = 0; b < SW; b++) if (s[b]) old[8*b +: 8] = nw[8*b +: 8];
        return old;
    endfunction

    task automatic ibus_read(int a, string tag);
        ibus_req = 1; ibus_addr = AW'(a); #1;
        chk({tag, " ibus ready"}, DW'(ibus_ready), 1);
        tick(); ibus_req = 0;
        chk({tag, " ibus rvalid"}, DW'(ibus_rvalid), 1);
        chk({tag, " ibus rdata"}, ibus_rdata, model[a]);
    endtask

    initial begin
        // R1: reset state
        tick(); tick();
        chk("R1 dma_rvalid in reset", DW'(dma_rvalid), 0);
        chk("R1 dbus_rvalid in reset", DW'(dbus_rvalid), 0);
        chk("R1 ibus_rvalid in reset", DW'(ibus_rvalid), 0);
        rst = 0; tick();
        chk("R1 dma_ready after reset", DW'(dma_ready), 0);
        chk("R1 dbus_rvalid after reset", DW'(dbus_rvalid), 0);

        // R6: fill every word through the data bus
        for (int a = 0; a < DEPTH; a++) begin
            dbus_req = 1; dbus_we = 1; dbus_addr = AW'(a);
            dbus_wdata = DW'(32'h1000_0001 * (a + 3)); dbus_strb = '1;
            model[a] = dbus_wdata;
            tick();
        end
        idle(); tick();

        // R4/R5: read back every word through fetch, twice (fetch leaves it intact)
        for (int rep = 0; rep < 2; rep++)
            for (int a = 0; a < DEPTH; a++) ibus_read(a, rep == 0 ? "R5" : "R4");

        // R2/R3/R5: sweep all request combinations (reads, first DMA cycle)
        for (int m = 0; m < 8; m++) begin
            dma_req = m[0]; dbus_req = m[1]; ibus_req = m[2];
            dma_addr = 4'd1; dbus_addr = 4'd2; ibus_addr = 4'd3; #1;
            chk("R2 dbus_ready sweep", DW'(dbus_ready), DW'(m[1]));
            chk("R3 ibus_ready sweep", DW'(ibus_ready), DW'(m[2] && !(m[0] && m[1])));
            chk("R7 dma_ready first cycle", DW'(dma_ready), 0);
            tick();
            chk("R5 dbus_rvalid sweep", DW'(dbus_rvalid), DW'(m[1]));
            if (m[1]) chk("R5 dbus_rdata sweep", dbus_rdata, model[2]);
            chk("R10 dma_rvalid after wait", DW'(dma_rvalid), 0);
            idle(); tick();
        end

        // R6: partial strobe write, read back on data bus
        dbus_req = 1; dbus_we = 1; dbus_addr = 4'd3; dbus_wdata = 32'hAABB_CCDD; dbus_strb = 4'b0101;
        model[3] = merge(model[3], dbus_wdata, dbus_strb);
        tick();
        dbus_we = 0; #1;
        tick(); idle();
        chk("R6 strobe rvalid", DW'(dbus_rvalid), 1);
        chk("R6 strobe merge", dbus_rdata, model[3]);

        // R5: same-cycle write (data) and read (fetch) of one word gives old value
        dbus_req = 1; dbus_we = 1; dbus_addr = 4'd5; dbus_wdata = 32'h5555_AAAA; dbus_strb = '1;
        ibus_req = 1; ibus_addr = 4'd5;
        tick(); idle();
        chk("R5 read-before-write", ibus_rdata, model[5]);
        model[5] = 32'h5555_AAAA;
        ibus_read(5, "R6");

        // R7/R8: DMA write to word 7 with competing buses during the wait
        dma_req = 1; dma_we = 1; dma_addr = 4'd7; dma_wdata = 32'hD0D0_7777; dma_strb = '1;
        for (int c = 0; c < WT; c++) begin
            dbus_req = 1; dbus_we = 0; dbus_addr = 4'd7; ibus_req = 1; ibus_addr = 4'd0; #1;
            chk("R7 dma_ready in wait", DW'(dma_ready), 0);
            chk("R8 ibus stalled in wait", DW'(ibus_ready), 0);
            tick();
            chk("R7 no early dma write", dbus_rdata, model[7]);
        end
        dbus_req = 0; #1;
        chk("R3 ibus granted with one other", DW'(ibus_ready), 1);
        chk("R7 dma_ready at last cycle", DW'(dma_ready), 1);
        tick(); idle();
        model[7] = 32'hD0D0_7777;
        ibus_read(7, "R7");

        // R10: DMA read of word 2
        dma_req = 1; dma_we = 0; dma_addr = 4'd2;
        for (int c = 0; c < WT; c++) begin
            tick();
            chk("R10 no rvalid in wait", DW'(dma_rvalid), 0);
        end
        #1 chk("R10 dma_ready", DW'(dma_ready), 1);
        tick(); idle();
        chk("R10 dma_rvalid", DW'(dma_rvalid), 1);
        chk("R10 dma_rdata", dma_rdata, model[2]);

        // R9: same-word collision, DMA wins shared bytes
        dma_req = 1; dma_we = 1; dma_addr = 4'd9; dma_wdata = 32'h1122_3344; dma_strb = 4'b0011;
        for (int c = 0; c < WT; c++) tick();
        dbus_req = 1; dbus_we = 1; dbus_addr = 4'd9; dbus_wdata = 32'hEEFF_6677; dbus_strb = 4'b0110;
        #1 chk("R9 dma ready at collision", DW'(dma_ready), 1);
        model[9] = merge(merge(model[9], dbus_wdata, dbus_strb), dma_wdata, dma_strb);
        tick(); idle();
        ibus_read(9, "R9");

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin repeat (20000) @(posedge clk); n_chk++; n_fail++;
                  $display("FAIL watchdog actual=timeout expected=done"); end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule